// File: doc/BRIEF.md
# Rotary Dial Pulse Digit Capture

This block turns rotary dial pulses on a telephone loop into binary digits. The loop input is a digital make/break level: 0 is make (loop closed) and 1 is break (loop open). It is synchronised and then filtered so that short glitches are ignored. Every transition from make to break on the filtered level is one dial pulse. The first pulse of a train starts a fresh count at one, and every later pulse adds one. A retriggerable gap timer restarts on each pulse. The digit is finished when the timer runs out while the loop is in make.

The finished count is written into a 4-bit digit register, which holds it until the next digit arrives. A tone decoder shares the same register: each rising edge of its valid strobe loads its 4-bit code. A break that lasts longer than the longest legal dial pulse means the handset has gone on-hook. In that case the pending count is dropped and the held digit is kept. Each load of the register raises a new-digit pulse for one cycle. If a dial digit completes in the same cycle as a tone strobe edge, the dial digit is loaded and the strobe edge is dropped.

Top module: `dial_digit_capture`

## Requirements
- R1: A change of the loop level that lasts fewer than DEBOUNCE_CYC clock cycles has no effect on the pulse count.
- R2: Each make-to-break transition of the filtered loop level counts as one pulse. The first pulse after an idle loop gives a count of one, whatever the previous train held.
- R3: The count is plain 4-bit binary and wraps modulo 16. One pulse gives 4'b0001, ten pulses give 4'b1010, and sixteen pulses give 4'b0000.
- R4: Pulses spaced by fewer than GAP_CYC cycles of make belong to the same digit. Because the gap timer restarts on every pulse, a slow dial still yields one digit.
- R5: When GAP_CYC cycles pass after the last pulse and the loop is in make, digit_out takes the count and new_digit is high for exactly that one cycle.
- R6: A break held for MAX_BREAK_CYC cycles (on-hook) drops the pending count. digit_out keeps its value and new_digit stays low.
- R7: A rising edge of tone_valid loads tone_code into digit_out one cycle later and pulses new_digit. Holding tone_valid high does not cause another load.
- R8: digit_out changes only in a cycle in which new_digit is high.
- R9: After reset, digit_out is 4'b0000 and new_digit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| loop_in | input | 1 | Loop level, 0 = make, 1 = break, asynchronous |
| tone_valid | input | 1 | Tone decoder valid strobe; its rising edge loads tone_code |
| tone_code | input | 4 | Tone decoder digit code |
| digit_out | output | 4 | Held digit |
| new_digit | output | 1 | One-cycle pulse whenever digit_out is loaded |

## Verification
The bench builds the block with DEBOUNCE_CYC = 4, GAP_CYC = 60 and MAX_BREAK_CYC = 30. With these values, pulse trains, inter-digit gaps and on-hook breaks last only tens of cycles, so sixteen-pulse trains and repeated digits fit in a short run. The gap is twice the on-hook limit, so an on-hook break is always dropped before the gap could end. Glitches of two cycles sit below the filter length, and make periods of 45 cycles exercise the restart of the gap timer close to its limit.

// File: rtl/dial_pkg.sv
// Shared widths and types for the dial digit capture block.
package dial_pkg;
    localparam int DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/loop_conditioner.sv
// Synchronises the asynchronous loop level and accepts a new level only
// after it has been stable for DEBOUNCE_CYC cycles.
// Assumes: DEBOUNCE_CYC >= 2, SYNC_STAGES >= 2; reset level is make (0).
module loop_conditioner #(
    parameter int SYNC_STAGES  = 2,
    parameter int DEBOUNCE_CYC = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_in,
    output logic loop_sync,
    output logic loop_clean
);
    localparam int CW = $clog2(DEBOUNCE_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          stable_cnt;

    // Synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], loop_in};
    end

    assign loop_sync = sync_q[SYNC_STAGES-1];

    // Filter: adopt the synchronised level once it has differed long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loop_clean <= 1'b0;
            stable_cnt <= '0;
        end else if (loop_sync == loop_clean) begin
            stable_cnt <= '0;
        end else if (stable_cnt == CW'(DEBOUNCE_CYC - 1)) begin
            loop_clean <= loop_sync;
            stable_cnt <= '0;
        end else begin
            stable_cnt <= stable_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pulse_train_counter.sv
// Counts make-to-break edges of the filtered loop level. The gap timer
// restarts on each edge. Its expiry in make completes the digit, and its
// expiry in break drops it. A break lasting MAX_BREAK_CYC cycles also
// drops the train.
// Assumes: GAP_CYC and MAX_BREAK_CYC >= 2.
module pulse_train_counter
    import dial_pkg::*;
#(
    parameter int GAP_CYC       = 2000000,
    parameter int MAX_BREAK_CYC = 1000000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   loop_clean,
    output logic   dial_done,
    output digit_t dial_count
);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam int BW = $clog2(MAX_BREAK_CYC + 1);

    logic          clean_d;
    logic          in_train;
    logic [GW-1:0] gap_cnt;
    logic [BW-1:0] brk_cnt;
    logic          brk_edge;

    assign brk_edge = loop_clean & ~clean_d;

    // Break-length timer, saturating at its limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                brk_cnt <= '0;
        else if (!loop_clean)                      brk_cnt <= '0;
        else if (brk_cnt != BW'(MAX_BREAK_CYC - 1)) brk_cnt <= brk_cnt + 1'b1;
    end

    // Train state, pulse count and gap timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_d    <= 1'b0;
            in_train   <= 1'b0;
            gap_cnt    <= '0;
            dial_count <= '0;
            dial_done  <= 1'b0;
        end else begin
            clean_d   <= loop_clean;
            dial_done <= 1'b0;
            if (brk_edge) begin
                dial_count <= in_train ? dial_count + 1'b1 : digit_t'(1);
                in_train   <= 1'b1;
                gap_cnt    <= '0;
            end else if (in_train) begin
                if (loop_clean && brk_cnt == BW'(MAX_BREAK_CYC - 1)) begin
                    in_train <= 1'b0;
                end else if (gap_cnt == GW'(GAP_CYC - 1)) begin
                    in_train  <= 1'b0;
                    dial_done <= ~loop_clean;
                end else begin
                    gap_cnt <= gap_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/digit_register.sv
// Holds the current digit. It loads from the dial counter on completion,
// or from the tone code on a rising edge of the tone valid strobe; the
// dial source wins on a tie. Pulses new_digit on each load.
module digit_register
    import dial_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   dial_done,
    input  digit_t dial_count,
    input  logic   tone_valid,
    input  digit_t tone_code,
    output digit_t digit_out,
    output logic   new_digit
);
    logic tone_d;
    logic tone_rise;

    assign tone_rise = tone_valid & ~tone_d;

    // Edge detector and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tone_d    <= 1'b0;
            digit_out <= '0;
            new_digit <= 1'b0;
        end else begin
            tone_d    <= tone_valid;
            new_digit <= dial_done | tone_rise;
            if (dial_done)      digit_out <= dial_count;
            else if (tone_rise) digit_out <= tone_code;
        end
    end
endmodule

// File: rtl/dial_digit_capture.sv
// Top level: loop conditioning, dial pulse counting and the shared digit
// register fed by the dial counter or by an external tone decoder.
// Assumes: MAX_BREAK_CYC < GAP_CYC, and longer than any legal dial break.
module dial_digit_capture
    import dial_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int DEBOUNCE_CYC  = 50000,
    parameter int GAP_CYC       = 2000000,
    parameter int MAX_BREAK_CYC = 1000000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         loop_in,
    input  logic         tone_valid,
    input  logic [3:0]   tone_code,
    output logic [3:0]   digit_out,
    output logic         new_digit
);
    logic   loop_sync;
    logic   loop_clean;
    logic   dial_done;
    digit_t dial_count;

    loop_conditioner #(
        .SYNC_STAGES (SYNC_STAGES),
        .DEBOUNCE_CYC(DEBOUNCE_CYC)
    ) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .loop_in   (loop_in),
        .loop_sync (loop_sync),
        .loop_clean(loop_clean)
    );

    pulse_train_counter #(
        .GAP_CYC      (GAP_CYC),
        .MAX_BREAK_CYC(MAX_BREAK_CYC)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .loop_clean(loop_clean),
        .dial_done (dial_done),
        .dial_count(dial_count)
    );

    digit_register u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .dial_done (dial_done),
        .dial_count(dial_count),
        .tone_valid(tone_valid),
        .tone_code (tone_code),
        .digit_out (digit_out),
        .new_digit (new_digit)
    );
endmodule

// File: rtl/dial_digit_checker.sv
// Property checks for dial_digit_capture, attached with bind.
module dial_digit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       loop_sync,
    input logic       loop_clean,
    input logic       dial_done,
    input logic [3:0] dial_count,
    input logic       tone_valid,
    input logic [3:0] tone_code,
    input logic [3:0] digit_out,
    input logic       new_digit
);
    // R1: the filtered level only ever moves toward the synchronised level.
    assert_filter_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(loop_clean) |-> loop_clean == $past(loop_sync));

    // R6: a digit is never completed while the loop is in break.
    assert_no_latch_in_break_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dial_done |-> !loop_clean);

    // R5: a completed digit reaches the output with a new-digit pulse.
    assert_dial_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dial_done |=> new_digit && digit_out == $past(dial_count));

    // R7: a tone strobe edge loads the tone code.
    assert_tone_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tone_valid) && !dial_done |=> new_digit && digit_out == $past(tone_code));

    // R8: the held digit changes only together with new_digit.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(digit_out) |-> new_digit);
endmodule

bind dial_digit_capture dial_digit_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .loop_sync (loop_sync),
    .loop_clean(loop_clean),
    .dial_done (dial_done),
    .dial_count(dial_count),
    .tone_valid(tone_valid),
    .tone_code (tone_code),
    .digit_out (digit_out),
    .new_digit (new_digit)
);

// File: tb/sim_dial_digit_capture.sv
module sim_dial_digit_capture;
    localparam int DEB  = 4;
    localparam int GAP  = 60;
    localparam int MAXB = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       loop_in = 1'b0;
    logic       tone_valid = 1'b0;
    logic [3:0] tone_code = '0;
    logic [3:0] digit_out;
    logic       new_digit;

    int checks = 0;
    int failures = 0;
    logic [3:0] expq[$];
    string      tagq[$];
    logic [3:0] last_digit = '0;
    logic       mon_on = 1'b0;

    always #5 clk = ~clk;

    dial_digit_capture #(
        .DEBOUNCE_CYC (DEB),
        .GAP_CYC      (GAP),
        .MAX_BREAK_CYC(MAXB)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .loop_in(loop_in),
        .tone_valid(tone_valid), .tone_code(tone_code),
        .digit_out(digit_out), .new_digit(new_digit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pop expected digits as loads appear; flag unexpected changes.
    always @(negedge clk) begin
        if (mon_on) begin
            if (new_digit) begin
                if (expq.size() == 0) begin
                    check(0, "R6/R7 unexpected load", digit_out, last_digit);
                end else begin
                    automatic logic [3:0] e = expq.pop_front();
                    automatic string t = tagq.pop_front();
                    check(digit_out == e, t, digit_out, e);
                end
                last_digit = digit_out;
            end else if (digit_out != last_digit) begin
                check(0, "R8 digit changed without pulse", digit_out, last_digit);
                last_digit = digit_out;
            end
        end
    end

    task automatic hold(input logic lvl, input int n);
        loop_in = lvl;
        repeat (n) @(negedge clk);
    endtask

    // Driver: dial n pulses, make length mk between pulses, optional glitches.
    task automatic dial(input int n, input int mk, input bit glitch, input string tag);
        expq.push_back(4'(n));
        tagq.push_back(tag);
        for (int i = 0; i < n; i++) begin
            hold(1'b1, 10);
            if (glitch) begin
                hold(1'b0, 4); hold(1'b1, 2); hold(1'b0, mk - 6);
            end else begin
                hold(1'b0, mk);
            end
        end
        hold(1'b0, GAP + 20);
        check(expq.size() == 0, {tag, " digit delivered"}, expq.size(), 0);
    endtask

    task automatic tone(input logic [3:0] c, input string tag);
        expq.push_back(c);
        tagq.push_back(tag);
        tone_code = c;
        tone_valid = 1'b1;
        repeat (50) @(negedge clk);
        tone_valid = 1'b0;
        repeat (5) @(negedge clk);
        check(expq.size() == 0, {tag, " single load"}, expq.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        check(digit_out == 4'd0, "R9 digit after reset", digit_out, 0);
        check(new_digit == 1'b0, "R9 pulse after reset", new_digit, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (10) @(negedge clk);

        dial(3, 10, 1'b0, "R2/R5 three pulses");
        dial(1, 10, 1'b0, "R2 single pulse restarts at one");
        dial(10, 10, 1'b0, "R3 ten pulses give 1010");
        dial(4, 10, 1'b1, "R1 glitches ignored");
        dial(7, 45, 1'b0, "R4 slow dial one digit");
        dial(16, 10, 1'b0, "R3 sixteen pulses wrap");
        dial(5, 10, 1'b0, "R5 after wrap");

        // R6: on-hook break is dropped
        hold(1'b1, 150);
        hold(1'b0, GAP + 40);
        check(digit_out == 4'd5, "R6 held digit after on-hook", digit_out, 5);
        check(expq.size() == 0, "R6 no pending", expq.size(), 0);

        tone(4'hB, "R7 tone load");
        dial(2, 10, 1'b0, "R5 dial after tone");
        tone(4'h0, "R7 tone zero code");

        repeat (20) @(negedge clk);
        check(digit_out == 4'h0, "R8 final hold", digit_out, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule